// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block holds a small queue of pending DRAM read and write requests and, every cycle, decides which one moves forward and which DRAM command that takes. Each queued entry carries a bank, a row, a read/write flag and an insertion sequence number. An external timing tracker marks each queue slot as ready or not through a per-slot ready vector; the scheduler never looks past that flag.

A per-bank table tracks which row each bank currently has open. In the default mode, ready requests that hit their bank's open row are served first, and ties are broken by age. A mode input switches to a strict oldest-ready order for comparison. A request that misses produces a precharge (bank open on another row) or an activate (bank closed) before its column access. A separate close-page input lets the scheduler close idle banks early when no queued entry still wants the open row.

The command appears combinationally on the outputs and takes effect at the next rising clock edge: the row table updates and a column command removes its entry from the queue.

Top module: `mem_req_sched`

## Requirements
- R1: While rst_ni is low and after its release, the queue is empty, every bank is closed and cmd_valid_o is low.
- R2: An accepted push stores the request in the lowest-numbered free slot with the next sequence number; a push while all DEPTH slots are occupied is dropped and never produces a command.
- R3: Only a slot that holds a request and has its ready_i bit set can produce a command; a request whose ready bit is low waits.
- R4: With mode_fcfs_i low, any ready request whose row equals the open row of its bank is chosen before every ready request that misses.
- R5: Among chosen-candidates of equal priority, the one inserted earliest wins.
- R6: With mode_fcfs_i high, the earliest-inserted ready request is chosen whether it hits or not.
- R7: For the chosen request, cmd_o is 2 (read) or 3 (write) when it hits the open row, and the entry then leaves the queue; 0 (precharge) when its bank has another row open; 1 (activate) when its bank is closed. cmd_idx_o, cmd_bank_o and cmd_row_o give the entry's slot, bank and row.
- R8: An activate opens cmd_row_o in cmd_bank_o; a precharge closes cmd_bank_o; a column command needs its bank open on its row.
- R9: With close_page_i high and no request producing a command, a precharge (cmd_o 0, cmd_idx_o 0, cmd_row_o the open row) is issued to the lowest-numbered open bank whose open row no queued entry, ready or not, targets.
- R10: With close_page_i low, or with every open bank still targeted by a queued entry, an idle scheduler issues no command and banks stay open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_fcfs_i | input | 1 | 1: strict oldest-ready order; 0: row hits first |
| close_page_i | input | 1 | Enables early precharge of idle banks |
| push_i | input | 1 | Enqueue a request this cycle |
| push_bank_i | input | BANK_W | Bank of the pushed request |
| push_row_i | input | ROW_W | Row of the pushed request |
| push_wr_i | input | 1 | 1: write, 0: read |
| ready_i | input | DEPTH | Per-slot ready flag from timing logic |
| cmd_valid_o | output | 1 | A command is issued at the next edge |
| cmd_o | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_idx_o | output | IDX_W | Queue slot of the request behind the command |
| cmd_bank_o | output | BANK_W | Target bank |
| cmd_row_o | output | ROW_W | Target row |

## Verification
The hardest state to reach is a queue holding several requests whose relative age, hit status and readiness disagree, because commands start flowing the moment an entry becomes ready. The stimulus fills the queue with every ready bit low, then opens the ready vector all at once or slot by slot, so the full precharge/activate/column sequence is known in advance and queued in the scoreboard. The same request set is replayed in both ordering modes to show the hit reordering, and the close-page case parks a non-ready entry on the open row to show that the early precharge is held back until that entry drains.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;
endpackage

// File: rtl/sched_req_queue.sv
module sched_req_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int SEQ_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [BANK_W-1:0]            push_bank_i,
  input  logic [ROW_W-1:0]             push_row_i,
  input  logic                         push_wr_i,
  input  logic                         pop_i,
  input  logic [IDX_W-1:0]             pop_idx_i,
  output logic [DEPTH-1:0]             valid_o,
  output logic [DEPTH-1:0][BANK_W-1:0] bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]  row_o,
  output logic [DEPTH-1:0]             wr_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]  seq_o
);
  logic [DEPTH-1:0]             valid_q;
  logic [DEPTH-1:0][BANK_W-1:0] bank_q;
  logic [DEPTH-1:0][ROW_W-1:0]  row_q;
  logic [DEPTH-1:0]             wr_q;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;
  logic [SEQ_W-1:0]             next_seq_q;
  logic                         full;
  logic [IDX_W-1:0]             free_idx;

  assign full = &valid_q;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) free_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      bank_q     <= '0;
      row_q      <= '0;
      wr_q       <= '0;
      seq_q      <= '0;
      next_seq_q <= '0;
    end else begin
      if (pop_i) valid_q[pop_idx_i] <= 1'b0;
      // full check uses pre-pop occupancy: a same-cycle pop frees no slot
      if (push_i && !full) begin
        valid_q[free_idx] <= 1'b1;
        bank_q[free_idx]  <= push_bank_i;
        row_q[free_idx]   <= push_row_i;
        wr_q[free_idx]    <= push_wr_i;
        seq_q[free_idx]   <= next_seq_q;
        next_seq_q        <= next_seq_q + 1'b1;
      end
    end
  end

  assign valid_o = valid_q;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign wr_o    = wr_q;
  assign seq_o   = seq_q;

  a_r2_push_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full && !pop_i) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));

  a_r2_full_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> $stable(valid_q) && $stable(seq_q));
endmodule

// File: rtl/sched_row_table.sv
module sched_row_table #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        act_i,
  input  logic                        pre_i,
  input  logic [BANK_W-1:0]           bank_i,
  input  logic [ROW_W-1:0]            row_i,
  output logic [NBANK-1:0]            open_vld_o,
  output logic [NBANK-1:0][ROW_W-1:0] open_row_o
);
  logic [NBANK-1:0]            open_vld_q;
  logic [NBANK-1:0][ROW_W-1:0] open_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_vld_q <= '0;
      open_row_q <= '0;
    end else if (act_i) begin
      open_vld_q[bank_i] <= 1'b1;
      open_row_q[bank_i] <= row_i;
    end else if (pre_i) begin
      open_vld_q[bank_i] <= 1'b0;
    end
  end

  assign open_vld_o = open_vld_q;
  assign open_row_o = open_row_q;

  a_r8_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_vld_q[$past(bank_i)] && (open_row_q[$past(bank_i)] == $past(row_i)));

  a_r8_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !act_i) |=> !open_vld_q[$past(bank_i)]);
endmodule

// File: rtl/sched_req_pick.sv
module sched_req_pick #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int SEQ_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic                         mode_fcfs_i,
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0]             ready_i,
  input  logic [DEPTH-1:0][BANK_W-1:0] bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]  row_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0]  seq_i,
  input  logic [NBANK-1:0]             open_vld_i,
  input  logic [NBANK-1:0][ROW_W-1:0]  open_row_i,
  output logic                         sel_vld_o,
  output logic [IDX_W-1:0]             sel_idx_o,
  output logic                         sel_hit_o
);
  logic [DEPTH-1:0] hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit[i] = open_vld_i[bank_i[i]] && (open_row_i[bank_i[i]] == row_i[i]);
  end

  // modular age compare: a older than b when (a - b) is negative
  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  always_comb begin
    logic             best_prio;
    logic [SEQ_W-1:0] best_seq;
    logic             prio;
    sel_vld_o = 1'b0;
    sel_idx_o = '0;
    sel_hit_o = 1'b0;
    best_prio = 1'b0;
    best_seq  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      prio = hit[i] && !mode_fcfs_i;
      if (valid_i[i] && ready_i[i]) begin
        if (!sel_vld_o || (prio && !best_prio) ||
            ((prio == best_prio) && older(seq_i[i], best_seq))) begin
          sel_vld_o = 1'b1;
          sel_idx_o = IDX_W'(i);
          sel_hit_o = hit[i];
          best_prio = prio;
          best_seq  = seq_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/sched_idle_close.sv
module sched_idle_close #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic [DEPTH-1:0]             valid_i,
  input  logic [DEPTH-1:0][BANK_W-1:0] bank_i,
  input  logic [DEPTH-1:0][ROW_W-1:0]  row_i,
  input  logic [NBANK-1:0]             open_vld_i,
  input  logic [NBANK-1:0][ROW_W-1:0]  open_row_i,
  output logic                         pre_vld_o,
  output logic [BANK_W-1:0]            pre_bank_o
);
  logic [NBANK-1:0] wanted;
  logic [NBANK-1:0] idle;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb begin
      wanted[b] = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (valid_i[i] && (bank_i[i] == BANK_W'(b)) && (row_i[i] == open_row_i[b]))
          wanted[b] = 1'b1;
      end
    end
    assign idle[b] = open_vld_i[b] && !wanted[b];
  end

  always_comb begin
    pre_vld_o  = |idle;
    pre_bank_o = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (idle[b]) pre_bank_o = BANK_W'(b);
    end
  end
endmodule

// File: rtl/mem_req_sched.sv
module mem_req_sched #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int SEQ_W  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NBANK = 1 << BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_fcfs_i,
  input  logic              close_page_i,
  input  logic              push_i,
  input  logic [BANK_W-1:0] push_bank_i,
  input  logic [ROW_W-1:0]  push_row_i,
  input  logic              push_wr_i,
  input  logic [DEPTH-1:0]  ready_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_o,
  output logic [IDX_W-1:0]  cmd_idx_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o
);
  import sched_pkg::*;

  logic [DEPTH-1:0]             q_valid;
  logic [DEPTH-1:0][BANK_W-1:0] q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  q_row;
  logic [DEPTH-1:0]             q_wr;
  logic [DEPTH-1:0][SEQ_W-1:0]  q_seq;
  logic [NBANK-1:0]             open_vld;
  logic [NBANK-1:0][ROW_W-1:0]  open_row;
  logic                         sel_vld, sel_hit;
  logic [IDX_W-1:0]             sel_idx;
  logic                         ep_vld;
  logic [BANK_W-1:0]            ep_bank;
  cmd_e                         cmd;
  logic                         pop, act, pre;

  sched_req_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .SEQ_W(SEQ_W)) u_queue (
    .clk_i, .rst_ni,
    .push_i, .push_bank_i, .push_row_i, .push_wr_i,
    .pop_i(pop), .pop_idx_i(sel_idx),
    .valid_o(q_valid), .bank_o(q_bank), .row_o(q_row), .wr_o(q_wr), .seq_o(q_seq)
  );

  sched_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk_i, .rst_ni,
    .act_i(act), .pre_i(pre), .bank_i(cmd_bank_o), .row_i(cmd_row_o),
    .open_vld_o(open_vld), .open_row_o(open_row)
  );

  sched_req_pick #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .SEQ_W(SEQ_W)) u_pick (
    .mode_fcfs_i,
    .valid_i(q_valid), .ready_i, .bank_i(q_bank), .row_i(q_row), .seq_i(q_seq),
    .open_vld_i(open_vld), .open_row_i(open_row),
    .sel_vld_o(sel_vld), .sel_idx_o(sel_idx), .sel_hit_o(sel_hit)
  );

  sched_idle_close #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_close (
    .valid_i(q_valid), .bank_i(q_bank), .row_i(q_row),
    .open_vld_i(open_vld), .open_row_i(open_row),
    .pre_vld_o(ep_vld), .pre_bank_o(ep_bank)
  );

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd         = CMD_PRE;
    cmd_idx_o   = '0;
    cmd_bank_o  = '0;
    cmd_row_o   = '0;
    if (sel_vld) begin
      cmd_valid_o = 1'b1;
      cmd_idx_o   = sel_idx;
      cmd_bank_o  = q_bank[sel_idx];
      cmd_row_o   = q_row[sel_idx];
      if (sel_hit)                   cmd = q_wr[sel_idx] ? CMD_WR : CMD_RD;
      else if (open_vld[cmd_bank_o]) cmd = CMD_PRE;
      else                           cmd = CMD_ACT;
    end else if (close_page_i && ep_vld) begin
      cmd_valid_o = 1'b1;
      cmd_bank_o  = ep_bank;
      cmd_row_o   = open_row[ep_bank];
    end
  end

  assign cmd_o = cmd;
  assign pop   = cmd_valid_o && ((cmd == CMD_RD) || (cmd == CMD_WR));
  assign act   = cmd_valid_o && (cmd == CMD_ACT);
  assign pre   = cmd_valid_o && (cmd == CMD_PRE);

  a_r8_col_on_open_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> open_vld[cmd_bank_o] && (open_row[cmd_bank_o] == cmd_row_o));

  a_r8_act_on_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> !open_vld[cmd_bank_o]);

  a_r3_col_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> ready_i[cmd_idx_o] && q_valid[cmd_idx_o]);

  a_r10_quiet_when_open_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!close_page_i && !(|(q_valid & ready_i))) |-> !cmd_valid_o);

  a_r1_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !cmd_valid_o);
endmodule

// File: tb/tb_mem_req_sched.sv
module tb_mem_req_sched;
  localparam int DEPTH  = 8;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 14;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mode_fcfs_i = 1'b0;
  logic              close_page_i = 1'b0;
  logic              push_i = 1'b0;
  logic [BANK_W-1:0] push_bank_i = '0;
  logic [ROW_W-1:0]  push_row_i = '0;
  logic              push_wr_i = 1'b0;
  logic [DEPTH-1:0]  ready_i = '0;
  logic              cmd_valid_o;
  logic [1:0]        cmd_o;
  logic [IDX_W-1:0]  cmd_idx_o;
  logic [BANK_W-1:0] cmd_bank_o;
  logic [ROW_W-1:0]  cmd_row_o;

  mem_req_sched dut (
    .clk_i(clk), .rst_ni, .mode_fcfs_i, .close_page_i,
    .push_i, .push_bank_i, .push_row_i, .push_wr_i, .ready_i,
    .cmd_valid_o, .cmd_o, .cmd_idx_o, .cmd_bank_o, .cmd_row_o
  );

  always #10 clk = ~clk;

  typedef struct {
    int    cmd;
    int    idx;
    int    bank;
    int    row;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  localparam int PRE = 0, ACT = 1, RD = 2, WR = 3;

  task automatic expect_cmd(int c, int i, int b, int r, string req);
    exp_t e;
    e.cmd = c; e.idx = i; e.bank = b; e.row = r; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic push_req(int b, int r, bit w);
    @(negedge clk);
    push_i = 1'b1; push_bank_i = BANK_W'(b); push_row_i = ROW_W'(r); push_wr_i = w;
    @(posedge clk);
    #1 push_i = 1'b0;
  endtask

  task automatic set_ready(logic [DEPTH-1:0] v);
    @(negedge clk);
    ready_i = v;
  endtask

  task automatic do_reset(bit fcfs, bit cp);
    @(negedge clk);
    rst_ni = 1'b0; ready_i = '0; mode_fcfs_i = fcfs; close_page_i = cp;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic drain(string req);
    for (int n = 0; n < 300 && exp_q.size() != 0; n++) @(posedge clk);
    repeat (6) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected commands never issued (got %0d, expected 0 left)",
               req, exp_q.size(), exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor: sample mid-low phase, after the driver has settled inputs
  initial begin
    forever begin
      @(posedge clk);
      #15;
      if (rst_ni && cmd_valid_o) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10: unexpected cmd=%0d idx=%0d bank=%0d row=%0d, expected none",
                   cmd_o, cmd_idx_o, cmd_bank_o, cmd_row_o);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (cmd_o != e.cmd || cmd_idx_o != e.idx || cmd_bank_o != e.bank || cmd_row_o != e.row) begin
            fails++;
            $display("FAIL %s: got cmd=%0d idx=%0d bank=%0d row=%0d, expected cmd=%0d idx=%0d bank=%0d row=%0d",
                     e.req, cmd_o, cmd_idx_o, cmd_bank_o, cmd_row_o, e.cmd, e.idx, e.bank, e.row);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (cmd_valid_o !== 1'b0) begin
      fails++; $display("FAIL R1: cmd_valid_o=%b in reset, expected 0", cmd_valid_o);
    end

    // A: row hits first (R4, R5, R7, R8)
    do_reset(1'b0, 1'b0);
    push_req(0, 5, 0); push_req(0, 7, 1); push_req(0, 5, 1);
    expect_cmd(ACT, 0, 0, 5, "R7_act_closed");
    expect_cmd(RD,  0, 0, 5, "R5_oldest_hit");
    expect_cmd(WR,  2, 0, 5, "R4_hit_before_older_miss");
    expect_cmd(PRE, 1, 0, 7, "R7_pre_other_row");
    expect_cmd(ACT, 1, 0, 7, "R8_pre_closed_bank");
    expect_cmd(WR,  1, 0, 7, "R8_act_opened_row");
    set_ready('1);
    drain("R4");

    // B: strict age order, same requests (R6)
    do_reset(1'b1, 1'b0);
    push_req(0, 5, 0); push_req(0, 7, 1); push_req(0, 5, 1);
    expect_cmd(ACT, 0, 0, 5, "R6_first");
    expect_cmd(RD,  0, 0, 5, "R6_first_col");
    expect_cmd(PRE, 1, 0, 7, "R6_oldest_miss_wins");
    expect_cmd(ACT, 1, 0, 7, "R6_act");
    expect_cmd(WR,  1, 0, 7, "R6_col");
    expect_cmd(PRE, 2, 0, 5, "R6_reopen_pre");
    expect_cmd(ACT, 2, 0, 5, "R6_reopen_act");
    expect_cmd(WR,  2, 0, 5, "R6_last_col");
    set_ready('1);
    drain("R6");

    // C: close page, early precharge after queue empties (R9)
    do_reset(1'b0, 1'b1);
    push_req(1, 3, 0); push_req(2, 4, 0);
    expect_cmd(ACT, 0, 1, 3, "R9_act_b1");
    expect_cmd(RD,  0, 1, 3, "R4_hit_b1");
    expect_cmd(ACT, 1, 2, 4, "R9_request_before_early_pre");
    expect_cmd(RD,  1, 2, 4, "R9_col_b2");
    expect_cmd(PRE, 0, 1, 3, "R9_early_pre_lowest_bank");
    expect_cmd(PRE, 0, 2, 4, "R9_early_pre_next_bank");
    set_ready('1);
    drain("R9");

    // D: readiness gates selection (R3)
    do_reset(1'b0, 1'b0);
    push_req(3, 1, 0); push_req(4, 2, 0);
    expect_cmd(ACT, 1, 4, 2, "R3_only_ready_slot");
    expect_cmd(RD,  1, 4, 2, "R3_only_ready_col");
    set_ready(8'b0000_0010);
    drain("R3");
    expect_cmd(ACT, 0, 3, 1, "R3_late_ready");
    expect_cmd(RD,  0, 3, 1, "R3_late_ready_col");
    set_ready(8'b0000_0011);
    drain("R3");

    // E: full queue drops the ninth push (R2)
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < DEPTH + 1; k++) push_req(5, 10 + k, 0);
    expect_cmd(ACT, 0, 5, 10, "R2_slot0");
    expect_cmd(RD,  0, 5, 10, "R2_slot0_col");
    for (int k = 1; k < DEPTH; k++) begin
      expect_cmd(PRE, k, 5, 10 + k, "R2_fill_order");
      expect_cmd(ACT, k, 5, 10 + k, "R2_fill_order");
      expect_cmd(RD,  k, 5, 10 + k, "R2_fill_order");
    end
    set_ready('1);
    drain("R2");

    // F: queued non-ready hit holds the bank open under close page (R9, R10)
    do_reset(1'b0, 1'b1);
    push_req(6, 9, 0); push_req(6, 9, 1);
    expect_cmd(ACT, 0, 6, 9, "R10_act");
    expect_cmd(RD,  0, 6, 9, "R10_col");
    set_ready(8'b0000_0001);
    drain("R10");
    expect_cmd(WR,  1, 6, 9, "R10_waiting_hit_kept_row");
    expect_cmd(PRE, 0, 6, 9, "R9_pre_after_last_hit");
    set_ready(8'b0000_0010);
    drain("R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule